// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block turns the short operand of a register-file instruction into a full data memory address and serves the read or write at that address. The data space is 12 bits wide and split into sixteen 256-byte banks. An operand reaches a bank in one of three ways:

- through a 4-bit bank selector held in the block;
- through a fixed 256-byte window that joins the bottom of bank 0 to the top of bank 15;
- through a complete 12-bit address supplied for register-to-register moves.

The bank selector loads from an immediate literal. It also sits at a fixed address in bank 15, so ordinary data accesses can read and write it. Only some banks have storage. Bank 15 always has storage, and banks 0 up to a parameter limit have it too. Every other bank reads as zero and drops writes. Storage writes on the rising clock edge. Reads are combinational.

Top module: `banked_addr_unit`

## Requirements
- R1: With `full_en` low and `bank_mode` high, `mem_addr` equals the 4-bit bank selector in bits 11:8 and `opnd` in bits 7:0.
- R2: With `full_en` low and `bank_mode` low, the bank selector is ignored. Operands below 60h map to 000h+operand, and operands 60h..FFh map to F00h+operand.
- R3: With `full_en` high, `mem_addr` equals `full_addr` whatever `bank_mode` and the bank selector hold.
- R4: The bank selector resets to 0. When `bank_ld` is high at a rising edge, the low nibble of `bank_lit` loads and is used from the next cycle on.
- R5: A read of address FE0h returns the bank selector in bits 3:0 and zero in bits 7:4, even after a literal or data write with nonzero upper bits.
- R6: A write of `wr_data` to address FE0h loads only bits 3:0 into the bank selector.
- R7: A read in an unimplemented bank returns 00h. Banks 0..IMPL_BANKS-1 and bank 15 are implemented, and IMPL_BANKS defaults to 2.
- R8: A write in an unimplemented bank changes no stored byte. In particular, the same offset in bank 0 keeps its value.
- R9: A write lands at the rising edge. A read in an implemented bank returns the last byte written there in the same cycle its address is applied.
- R10: With `rd_en` low, `rd_data` is 00h.
- R11: When `bank_ld` and a data write to FE0h occur in the same cycle, the literal wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| opnd | input | 8 | Direct-address operand |
| bank_mode | input | 1 | 1: use bank selector, 0: use access window |
| full_en | input | 1 | Use the full 12-bit address path |
| full_addr | input | 12 | Full address for register-to-register moves |
| bank_ld | input | 1 | Load bank selector from literal |
| bank_lit | input | 8 | Literal bank value |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| mem_addr | output | 12 | Resolved 12-bit address |

## Verification
Operands are driven on both sides of the 60h window split and at its two ends (5Fh, 60h, FFh). This tells the window mapping apart from banked mapping while a nonzero bank is selected. The full-address path is driven with `bank_mode` set and a different bank loaded, which exposes any leak of the selector into the move path. Bytes are written at one offset in an implemented bank and an unimplemented bank. Reading both back separates real storage from aliasing or discarded writes. The selector is written both by literal and by data write, including upper-nibble ones and a same-cycle collision, to show the masking and the priority.

// File: rtl/bau_pkg.sv
`timescale 1ns/1ps
package bau_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 12;
    localparam int BANK_W  = 4;
    localparam int OFS_W   = ADDR_W - BANK_W;
    localparam int NBANKS  = 1 << BANK_W;
    localparam logic [BANK_W-1:0] TOP_BANK = BANK_W'(NBANKS - 1);

    typedef enum logic [1:0] {
        SRC_BANKED = 2'd0,
        SRC_WINDOW = 2'd1,
        SRC_FULL   = 2'd2
    } addr_src_e;

    typedef struct packed {
        logic [BANK_W-1:0] sel;
    } bank_state_t;
endpackage

// File: rtl/bau_addr_mux.sv
`timescale 1ns/1ps
module bau_addr_mux
    import bau_pkg::*;
#(
    parameter logic [OFS_W-1:0] WIN_SPLIT = 8'h60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OFS_W-1:0]     opnd,
    input  logic                 bank_mode,
    input  logic                 full_en,
    input  logic [ADDR_W-1:0]    full_addr,
    input  logic [BANK_W-1:0]    bank_sel,
    output logic [ADDR_W-1:0]    addr,
    output addr_src_e            src
);
    logic [BANK_W-1:0] win_bank;

    always_comb begin
        win_bank = (opnd < WIN_SPLIT) ? '0 : TOP_BANK;
        if (full_en) begin
            src  = SRC_FULL;
            addr = full_addr;
        end else if (bank_mode) begin
            src  = SRC_BANKED;
            addr = {bank_sel, opnd};
        end else begin
            src  = SRC_WINDOW;
            addr = {win_bank, opnd};
        end
    end

    // R2: window only ever lands in bank 0 or bank 15
    p_window_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_en && !bank_mode) |-> (addr[ADDR_W-1:OFS_W] == '0 || addr[ADDR_W-1:OFS_W] == TOP_BANK));

    // R2: offset bits pass through unchanged in the window
    p_window_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_en && !bank_mode) |-> (addr[OFS_W-1:0] == opnd));
endmodule

// File: rtl/bau_bank_reg.sv
`timescale 1ns/1ps
module bau_bank_reg
    import bau_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BSEL_ADDR = 12'hFE0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bank_ld,
    input  logic [DATA_W-1:0]    bank_lit,
    input  logic                 dwr_en,
    input  logic [ADDR_W-1:0]    daddr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [BANK_W-1:0]    bank_sel
);
    bank_state_t st_d, st_q;
    logic        data_hit;

    always_comb begin
        st_d     = st_q;
        data_hit = dwr_en && (daddr == BSEL_ADDR);
        if (bank_ld)
            st_d.sel = bank_lit[BANK_W-1:0];
        else if (data_hit)
            st_d.sel = wdata[BANK_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank_sel = st_q.sel;

    // R4: literal load seen one cycle later
    p_lit_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_ld |=> (bank_sel == $past(bank_lit[BANK_W-1:0])));

    // R11: literal beats a data write to the selector
    p_lit_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_ld && dwr_en && daddr == BSEL_ADDR) |=> (bank_sel == $past(bank_lit[BANK_W-1:0])));

    // R6: without a load source the selector holds
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_ld && !(dwr_en && daddr == BSEL_ADDR)) |=> $stable(bank_sel));
endmodule

// File: rtl/bau_data_store.sv
`timescale 1ns/1ps
module bau_data_store
    import bau_pkg::*;
#(
    parameter int IMPL_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 implemented
);
    localparam int ROWS  = IMPL_BANKS + 1;
    localparam int ROW_W = $clog2(ROWS);
    localparam int DEPTH = ROWS << OFS_W;
    localparam int IDX_W = ROW_W + OFS_W;

    logic [NBANKS-1:0]    impl_map;
    logic [BANK_W-1:0]    bank;
    logic [ROW_W-1:0]     row;
    logic [IDX_W-1:0]     idx;
    logic                 mem_we;
    logic [DATA_W-1:0]    mem [DEPTH];

    for (genvar b = 0; b < NBANKS; b++) begin : g_impl
        assign impl_map[b] = (b < IMPL_BANKS) || (b == NBANKS - 1);
    end

    always_comb begin
        bank        = addr[ADDR_W-1:OFS_W];
        implemented = impl_map[bank];
        row         = (bank == TOP_BANK) ? ROW_W'(IMPL_BANKS) : ROW_W'(bank);
        idx         = {row, addr[OFS_W-1:0]};
        mem_we      = wr_en && implemented;
        rdata       = (rd_en && implemented) ? mem[idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[idx] <= wdata;
    end

    // R7: unimplemented banks return zero
    p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(bank < BANK_W'(IMPL_BANKS) || bank == TOP_BANK)) |-> (rdata == '0));
endmodule

// File: rtl/banked_addr_unit.sv
`timescale 1ns/1ps
module banked_addr_unit
    import bau_pkg::*;
#(
    parameter int                IMPL_BANKS = 2,
    parameter logic [OFS_W-1:0]  WIN_SPLIT  = 8'h60,
    parameter logic [ADDR_W-1:0] BSEL_ADDR  = 12'hFE0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           opnd,
    input  logic                 bank_mode,
    input  logic                 full_en,
    input  logic [11:0]          full_addr,
    input  logic                 bank_ld,
    input  logic [7:0]           bank_lit,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    output logic [7:0]           rd_data,
    output logic [11:0]          mem_addr
);
    logic [BANK_W-1:0] bank_sel;
    logic [ADDR_W-1:0] addr;
    addr_src_e         src;
    logic [DATA_W-1:0] store_rd;
    logic              store_impl;
    logic              bsel_hit;
    logic              store_we;

    assign bsel_hit = (addr == BSEL_ADDR);
    assign store_we = wr_en && !bsel_hit;

    bau_addr_mux #(.WIN_SPLIT(WIN_SPLIT)) u_mux (
        .clk(clk), .rst_n(rst_n), .opnd(opnd), .bank_mode(bank_mode),
        .full_en(full_en), .full_addr(full_addr), .bank_sel(bank_sel),
        .addr(addr), .src(src)
    );

    bau_bank_reg #(.BSEL_ADDR(BSEL_ADDR)) u_bank (
        .clk(clk), .rst_n(rst_n), .bank_ld(bank_ld), .bank_lit(bank_lit),
        .dwr_en(wr_en), .daddr(addr), .wdata(wr_data), .bank_sel(bank_sel)
    );

    bau_data_store #(.IMPL_BANKS(IMPL_BANKS)) u_store (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en && !bsel_hit),
        .wr_en(store_we), .wdata(wr_data), .rdata(store_rd),
        .implemented(store_impl)
    );

    always_comb begin
        mem_addr = addr;
        if (!rd_en)        rd_data = '0;
        else if (bsel_hit) rd_data = {{(DATA_W-BANK_W){1'b0}}, bank_sel};
        else               rd_data = store_rd;
    end

    // R5: selector readback never shows upper bits
    p_bsel_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mem_addr == BSEL_ADDR) |-> (rd_data[7:BANK_W] == '0));

    // R10: idle read port is quiet
    p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));

    // R3: move path overrides both other sources
    p_full_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full_en |-> (src == SRC_FULL && mem_addr == full_addr));
endmodule

// File: tb/banked_addr_unit_test.sv
`timescale 1ns/1ps
module banked_addr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opnd = '0;
    logic        bank_mode = 1'b0;
    logic        full_en = 1'b0;
    logic [11:0] full_addr = '0;
    logic        bank_ld = 1'b0;
    logic [7:0]  bank_lit = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [11:0] mem_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    banked_addr_unit uut (
        .clk(clk), .rst_n(rst_n), .opnd(opnd), .bank_mode(bank_mode),
        .full_en(full_en), .full_addr(full_addr), .bank_ld(bank_ld),
        .bank_lit(bank_lit), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .mem_addr(mem_addr)
    );

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bank_ld = 0; wr_en = 0; rd_en = 0; full_en = 0;
    endtask

    // drive a banked/window operand and read (combinational)
    task automatic rd_op(input logic mode, input logic [7:0] op, output logic [7:0] d, output logic [11:0] a);
        @(negedge clk);
        bank_ld = 0; wr_en = 0; full_en = 0;
        bank_mode = mode; opnd = op; rd_en = 1;
        #1; d = rd_data; a = mem_addr;
        rd_en = 0;
    endtask

    task automatic wr_op(input logic mode, input logic [7:0] op, input logic [7:0] dat);
        @(negedge clk);
        bank_ld = 0; full_en = 0; bank_mode = mode; opnd = op;
        wr_data = dat; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_full(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        full_en = 1; full_addr = a; rd_en = 1; wr_en = 0;
        #1; d = rd_data;
        rd_en = 0; full_en = 0;
    endtask

    task automatic wr_full(input logic [11:0] a, input logic [7:0] dat);
        @(negedge clk);
        full_en = 1; full_addr = a; wr_data = dat; wr_en = 1;
        @(negedge clk); wr_en = 0; full_en = 0;
    endtask

    task automatic load_bank(input logic [7:0] lit);
        @(negedge clk);
        bank_ld = 1; bank_lit = lit;
        @(negedge clk); bank_ld = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic [11:0] a;
        rd_op(0, 8'hE0, d, a);
        chk("R4 reset selector", {4'h0, d}, 12'h000);
        rd_op(1, 8'h22, d, a);
        chk("R1 reset bank addr", a, 12'h022);
    endtask

    task automatic t_banked();
        logic [7:0] d; logic [11:0] a;
        load_bank(8'h01);
        rd_op(1, 8'h34, d, a);
        chk("R1 bank1 addr", a, 12'h134);
        wr_op(1, 8'h34, 8'h5A);
        rd_op(1, 8'h34, d, a);
        chk("R9 bank1 readback", {4'h0, d}, 12'h05A);
        rd_full(12'h034, d);
        chk("R1 bank0 untouched", {4'h0, d}, 12'h000 | {4'h0, d & 8'h00});
    endtask

    task automatic t_literal_upper();
        logic [7:0] d; logic [11:0] a;
        load_bank(8'hF1);
        rd_op(0, 8'hE0, d, a);
        chk("R5 literal upper masked", {4'h0, d}, 12'h001);
        rd_op(1, 8'h10, d, a);
        chk("R4 load effective", a, 12'h110);
    endtask

    task automatic t_window();
        logic [7:0] d; logic [11:0] a;
        rd_op(0, 8'h5F, d, a);
        chk("R2 window 5F", a, 12'h05F);
        rd_op(0, 8'h60, d, a);
        chk("R2 window 60", a, 12'hF60);
        rd_op(0, 8'hFF, d, a);
        chk("R2 window FF", a, 12'hFFF);
        rd_op(0, 8'h00, d, a);
        chk("R2 window 00", a, 12'h000);
    endtask

    task automatic t_full();
        logic [7:0] d;
        load_bank(8'h05);
        @(negedge clk);
        bank_mode = 1; opnd = 8'h99; full_en = 1; full_addr = 12'h1AB;
        #1; chk("R3 full overrides bank", mem_addr, 12'h1AB);
        full_en = 0;
        wr_full(12'h1AB, 8'h3C);
        rd_full(12'h1AB, d);
        chk("R3 full readback", {4'h0, d}, 12'h03C);
    endtask

    task automatic t_unimpl();
        logic [7:0] d; logic [11:0] a;
        wr_full(12'h077, 8'h11);
        load_bank(8'h05);
        wr_op(1, 8'h77, 8'hEE);
        rd_op(1, 8'h77, d, a);
        chk("R7 unimpl reads zero", {4'h0, d}, 12'h000);
        rd_full(12'h077, d);
        chk("R8 bank0 kept", {4'h0, d}, 12'h011);
        rd_full(12'h177, d);
        chk("R8 bank1 kept", {4'h0, d}, 12'h000);
    endtask

    task automatic t_sfr();
        logic [7:0] d; logic [11:0] a;
        wr_op(0, 8'h80, 8'hC3);
        rd_op(0, 8'h80, d, a);
        chk("R9 bank15 readback", {4'h0, d}, 12'h0C3);
        @(negedge clk);
        full_en = 1; full_addr = 12'hF80; rd_en = 1; wr_en = 1; wr_data = 8'h47;
        #1; chk("R9 read before edge", {4'h0, rd_data}, 12'h0C3);
        @(negedge clk); wr_en = 0;
        #1; chk("R9 read after edge", {4'h0, rd_data}, 12'h047);
        rd_en = 0; full_en = 0;
    endtask

    task automatic t_bsel_data();
        logic [7:0] d; logic [11:0] a;
        wr_op(0, 8'hE0, 8'hF3);
        rd_op(0, 8'hE0, d, a);
        chk("R6 data write low nibble", {4'h0, d}, 12'h003);
        rd_op(1, 8'h00, d, a);
        chk("R6 new bank used", a, 12'h300);
    endtask

    task automatic t_collision();
        logic [7:0] d; logic [11:0] a;
        @(negedge clk);
        bank_mode = 0; opnd = 8'hE0; full_en = 0;
        wr_en = 1; wr_data = 8'h07; bank_ld = 1; bank_lit = 8'h02;
        @(negedge clk); wr_en = 0; bank_ld = 0;
        rd_op(0, 8'hE0, d, a);
        chk("R11 literal wins", {4'h0, d}, 12'h002);
    endtask

    task automatic t_idle_read();
        @(negedge clk);
        full_en = 1; full_addr = 12'hF80; rd_en = 0;
        #1; chk("R10 idle read zero", {4'h0, rd_data}, 12'h000);
        full_en = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        t_reset();
        t_banked();
        t_literal_upper();
        t_window();
        t_full();
        t_unimpl();
        t_sfr();
        t_bsel_data();
        t_collision();
        t_idle_read();
        idle();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule